// File: doc/BRIEF.md
# Shadowed PWM Channel with Bit-Masked Control Writes

This block is a single pulse-width modulation channel with a small register file. Software sets a period count and a duty count, chooses which level the active phase and the idle phase drive, and starts the counter. Period, duty and polarity are held in shadow registers. A load request copies all three into the live counter logic in one cycle, but only at a period boundary. A lock bit can hold that copy back while software changes several fields, so the waveform never shows a mix of old and new settings.

The enable, clock-control and control registers use bit-masked writes. Bits [31:16] of the written word select which of the data bits [15:0] change, so one control bit can be set or cleared without reading the register first. The channel runs either continuously or for exactly one period. A prescaler divides the system clock down to the rate at which the counter advances.

Top module: `pwm_shadow_chan`

## Requirements
- R1: A write to offset 0x4, 0x8 or 0xC changes data bit i (i in 0..15) only when bit 16+i of the written word is 1. All other bits keep their values, and a read of the same offset shows the merged result.
- R2: Offset 0x0 is read-only. It reads the channel count in bits [3:0] and this channel's index in bits [7:4], and writes to it have no effect.
- R3: The enable register at 0x4 has these bits: bit 0 is counter clock enable, bit 1 is output enable, bit 2 is load request and bit 3 is lock. The counter runs only while bits 0 and 1 are both set and the mode is 0 or 1. Otherwise the output holds the live idle level.
- R4: The counter steps from 0 up to period-1 and then wraps. The output is registered. It drives the active level while the counter is below the live duty and the idle level otherwise. Control bit 2 = 1 makes the active level high, and control bit 3 = 1 makes the idle level high.
- R5: A live duty of 0 gives a constant idle level. A live duty equal to or greater than the period gives a constant active level.
- R6: Writes to 0x10 (period) and 0x14 (duty) take the low CNT_W bits into shadow registers, which read back from the same offsets. They leave the running waveform unchanged until they are loaded.
- R7: When the load request is set and lock is clear, shadow period, duty and polarity move into the live registers together. This happens on the counter wrap, or at once when the counter is stopped. The load request bit then clears itself.
- R8: While lock is set, the load request stays pending and the waveform is unchanged. When lock is cleared, the pending load takes effect at the next boundary.
- R9: Mode 0 (control bits [1:0] = 0) runs exactly one period. At the wrap the hardware clears the output enable bit and the output returns to idle.
- R10: When the output enable bit is cleared, the output drives the idle level from the following clock on.
- R11: Clock control bits [2:0] (prescale P) and [12:4] (scale S) make the counter advance once every (S+1)*2^P clocks.
- R12: Mode values 2 and 3 hold the counter at 0 and the output at the idle level.
- R13: After reset, enable and clock control read 0 and control reads 0x0005 (continuous mode, active high, idle low). Period and duty read 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write word: mask in [31:16] and data in [15:0] for control registers, count in the low bits for period and duty |
| rd_addr | input | ADDR_W | Byte offset of the combinational read |
| rd_data | output | 32 | Read data for rd_addr |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The properties assume that software never sets the load request in the same cycle as the hardware commit, and never writes the output enable in the same cycle as a one-shot wrap. They also assume that a live period of zero is only ever reached through reset. The stimulus keeps to these rules by waiting out a full boundary after each load request before it touches the enable register again. It loads configurations while the counter is stopped, or it lets the running period finish first. Under that discipline the bench's own model of the register merge, the prescaler and the commit rule gives an exact expected output for every clock.

// File: rtl/pwm_shadow_pkg.sv
`timescale 1ns/1ps
package pwm_shadow_pkg;
  // register byte offsets; the software map depends on these
  localparam int unsigned OFS_ID   = 0;
  localparam int unsigned OFS_EN   = 4;
  localparam int unsigned OFS_CLK  = 8;
  localparam int unsigned OFS_CTL  = 12;
  localparam int unsigned OFS_PER  = 16;
  localparam int unsigned OFS_DUTY = 20;

  // enable register bit positions
  localparam int unsigned EN_CLK  = 0;
  localparam int unsigned EN_OUT  = 1;
  localparam int unsigned EN_LOAD = 2;
  localparam int unsigned EN_LOCK = 3;

  localparam int unsigned PRE_W   = 3;
  localparam int unsigned SCALE_W = 9;
  localparam int unsigned CLK_W   = 13;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_CAP  = 2'd2,
    MODE_RSV  = 2'd3
  } run_mode_e;

  typedef struct packed {
    logic idle_hi;
    logic act_hi;
  } pol_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
`timescale 1ns/1ps
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CH_TOTAL = 1,
  parameter int unsigned CH_INDEX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  input  logic                commit_i,
  input  logic                once_done_i,
  output logic [3:0]          en_o,
  output logic [1:0]          mode_o,
  output pol_t                pol_o,
  output logic [CNT_W-1:0]    per_o,
  output logic [CNT_W-1:0]    duty_o,
  output logic [PRE_W-1:0]    pre_o,
  output logic [SCALE_W-1:0]  scale_o
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(OFS_CLK);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFS_PER);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(OFS_DUTY);
  localparam logic [CLK_W-1:0]  CLK_KEEP = 13'h1FF7;
  localparam logic [7:0] ID_VAL = {4'(CH_INDEX), 4'(CH_TOTAL)};

  logic [3:0]       en_q, en_d;
  logic [CLK_W-1:0] clk_q, clk_d;
  logic [3:0]       ctl_q, ctl_d;
  logic [CNT_W-1:0] per_q, per_d, duty_q, duty_d;
  logic             unused_wd;

  assign unused_wd = ^wr_data;

  always_comb begin
    en_d   = en_q;
    clk_d  = clk_q;
    ctl_d  = ctl_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (wr_en) begin
      case (wr_addr)
        A_EN:   en_d   = (en_q & ~wr_data[19:16]) | (wr_data[3:0] & wr_data[19:16]);
        A_CLK:  clk_d  = ((clk_q & ~wr_data[28:16]) | (wr_data[12:0] & wr_data[28:16])) & CLK_KEEP;
        A_CTL:  ctl_d  = (ctl_q & ~wr_data[19:16]) | (wr_data[3:0] & wr_data[19:16]);
        A_PER:  per_d  = wr_data[CNT_W-1:0];
        A_DUTY: duty_d = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
    if (commit_i)    en_d[EN_LOAD] = 1'b0;
    if (once_done_i) en_d[EN_OUT]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      clk_q  <= '0;
      ctl_q  <= 4'h5;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      en_q   <= en_d;
      clk_q  <= clk_d;
      ctl_q  <= ctl_d;
      per_q  <= per_d;
      duty_q <= duty_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_ID:   rd_data[7:0]       = ID_VAL;
      A_EN:   rd_data[3:0]       = en_q;
      A_CLK:  rd_data[CLK_W-1:0] = clk_q;
      A_CTL:  rd_data[3:0]       = ctl_q;
      A_PER:  rd_data[CNT_W-1:0] = per_q;
      A_DUTY: rd_data[CNT_W-1:0] = duty_q;
      default: ;
    endcase
  end

  assign en_o    = en_q;
  assign mode_o  = ctl_q[1:0];
  assign pol_o   = pol_t'(ctl_q[3:2]);
  assign per_o   = per_q;
  assign duty_o  = duty_q;
  assign pre_o   = clk_q[2:0];
  assign scale_o = clk_q[12:4];
endmodule

// File: rtl/pwm_shadow_presc.sv
`timescale 1ns/1ps
module pwm_shadow_presc
  import pwm_shadow_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [PRE_W-1:0]   pre_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);
  localparam int unsigned DIV_W = SCALE_W + 1 + (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, lim;

  assign lim    = ((DIV_W'(scale_i) + DIV_W'(1)) << pre_i) - DIV_W'(1);
  assign tick_o = run_i && (div_q == lim);

  always_comb begin
    if (!run_i || tick_o) div_d = '0;
    else                  div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_shadow_core.sv
`timescale 1ns/1ps
module pwm_shadow_core
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       en_i,
  input  logic [1:0]       mode_i,
  input  pol_t             pol_sh_i,
  input  logic [CNT_W-1:0] per_sh_i,
  input  logic [CNT_W-1:0] duty_sh_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             commit_o,
  output logic             once_done_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_live_o,
  output logic [CNT_W-1:0] duty_live_o,
  output pol_t             pol_live_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, duty_q, duty_d;
  pol_t             pol_q, pol_d;
  logic             out_q, out_d;
  logic             last, wrap;

  assign run_o       = en_i[EN_CLK] && en_i[EN_OUT] && !mode_i[1];
  assign last        = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};
  assign wrap        = run_o && tick_i && last;
  assign commit_o    = en_i[EN_LOAD] && !en_i[EN_LOCK] && (!run_o || wrap);
  assign once_done_o = wrap && (mode_i == MODE_ONCE);

  always_comb begin
    per_d  = per_q;
    duty_d = duty_q;
    pol_d  = pol_q;
    if (commit_o) begin
      per_d  = per_sh_i;
      duty_d = duty_sh_i;
      pol_d  = pol_sh_i;
    end
    if (!run_o)       cnt_d = '0;
    else if (!tick_i) cnt_d = cnt_q;
    else if (last)    cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    out_d = (run_o && (cnt_q < duty_q)) ? pol_q.act_hi : pol_q.idle_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      pol_q  <= '{idle_hi: 1'b0, act_hi: 1'b1};
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      pol_q  <= pol_d;
      out_q  <= out_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign per_live_o  = per_q;
  assign duty_live_o = duty_q;
  assign pol_live_o  = pol_q;
  assign pwm_o       = out_q;
endmodule

// File: rtl/pwm_shadow_chan.sv
`timescale 1ns/1ps
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CH_TOTAL = 1,
  parameter int unsigned CH_INDEX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              pwm_out
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [3:0]         en_w;
  logic [1:0]         mode_w;
  pol_t               pol_sh_w, pol_live_w;
  logic [CNT_W-1:0]   per_sh_w, duty_sh_w, cnt_w, per_live_w, duty_live_w;
  logic [PRE_W-1:0]   pre_w;
  logic [SCALE_W-1:0] scale_w;
  logic               run_w, tick_w, commit_w, once_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pwm_shadow_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CH_TOTAL(CH_TOTAL), .CH_INDEX(CH_INDEX)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .commit_i(commit_w), .once_done_i(once_w),
    .en_o(en_w), .mode_o(mode_w), .pol_o(pol_sh_w),
    .per_o(per_sh_w), .duty_o(duty_sh_w),
    .pre_o(pre_w), .scale_o(scale_w)
  );

  pwm_shadow_presc u_presc (
    .clk(clk), .rst_n(rst_sync_n),
    .run_i(run_w), .pre_i(pre_w), .scale_i(scale_w),
    .tick_o(tick_w)
  );

  pwm_shadow_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n),
    .en_i(en_w), .mode_i(mode_w), .pol_sh_i(pol_sh_w),
    .per_sh_i(per_sh_w), .duty_sh_i(duty_sh_w), .tick_i(tick_w),
    .run_o(run_w), .commit_o(commit_w), .once_done_o(once_w),
    .cnt_o(cnt_w), .per_live_o(per_live_w), .duty_live_o(duty_live_w),
    .pol_live_o(pol_live_w), .pwm_o(pwm_out)
  );
endmodule

// File: rtl/pwm_shadow_chan_chk.sv
`timescale 1ns/1ps
module pwm_shadow_chan_chk
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_out,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_live,
  input logic [CNT_W-1:0] duty_live,
  input pol_t             pol_live,
  input logic             load,
  input logic             lock,
  input logic [1:0]       mode
);
  // R10
  stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (pwm_out == $past(pol_live.idle_hi)));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && duty_live == '0) |=> (pwm_out == $past(pol_live.idle_hi)));

  // R5
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && duty_live != '0 && duty_live >= per_live) |=> (pwm_out == $past(pol_live.act_hi)));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt < per_live));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(per_live) && $stable(duty_live) && $stable(pol_live)));

  // R7
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(per_live) && $stable(duty_live) && $stable(pol_live)));

  // R12
  mode_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> (cnt == '0));
endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pwm_out(pwm_out), .running(run_w),
  .cnt(cnt_w), .per_live(per_live_w), .duty_live(duty_live_w),
  .pol_live(pol_live_w), .load(en_w[2]), .lock(en_w[3]), .mode(mode_w)
);

// File: tb/pwm_shadow_chan_test.sv
`timescale 1ns/1ps
module pwm_shadow_chan_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit model_on = 0;
  string cur_req = "R13";

  pwm_shadow_chan #(.CNT_W(16), .ADDR_W(5), .CH_TOTAL(4), .CH_INDEX(3)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference state
  int m_en, m_clkc, m_ctl, m_psh, m_dsh, m_per, m_duty, m_pol, m_cnt, m_pre;
  bit m_out;

  function automatic int mrg(int old, logic [31:0] d);
    int mk;
    mk = int'(d[31:16]);
    return (old & ~mk) | (int'(d[15:0]) & mk);
  endfunction

  always @(posedge clk or negedge rst_n) begin : ref_model
    int md, lim;
    bit run, tk, lst, wp, cm;
    if (!rst_n) begin
      m_en = 0; m_clkc = 0; m_ctl = 5; m_psh = 0; m_dsh = 0;
      m_per = 0; m_duty = 0; m_pol = 1; m_cnt = 0; m_pre = 0; m_out = 0;
    end else begin
      md  = m_ctl & 3;
      run = ((m_en & 1) != 0) && ((m_en & 2) != 0) && (md < 2);
      lim = (((m_clkc >> 4) & 511) + 1) << (m_clkc & 7);
      tk  = run && (m_pre + 1 == lim);
      lst = (m_cnt + 1 >= m_per);
      wp  = run && tk && lst;
      cm  = ((m_en & 4) != 0) && ((m_en & 8) == 0) && (!run || wp);
      if (run && m_cnt < m_duty) m_out = bit'(m_pol & 1);
      else                       m_out = bit'((m_pol >> 1) & 1);
      if (!run) begin m_cnt = 0; m_pre = 0; end
      else if (tk) begin m_pre = 0; m_cnt = lst ? 0 : m_cnt + 1; end
      else m_pre = m_pre + 1;
      if (cm) begin m_per = m_psh; m_duty = m_dsh; m_pol = (m_ctl >> 2) & 3; end
      if (wr_en) begin
        case (wr_addr)
          5'd4:  m_en   = mrg(m_en, wr_data) & 15;
          5'd8:  m_clkc = mrg(m_clkc, wr_data) & 'h1FF7;
          5'd12: m_ctl  = mrg(m_ctl, wr_data) & 15;
          5'd16: m_psh  = int'(wr_data[15:0]);
          5'd20: m_dsh  = int'(wr_data[15:0]);
          default: ;
        endcase
      end
      if (cm) m_en = m_en & ~4;
      if (wp && md == 0) m_en = m_en & ~2;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && model_on && !done) chk({cur_req, " per-clock"}, int'(pwm_out), int'(m_out));
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highs(int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int v, h;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(3);
    rst_n = 1'b1;
    model_on = 1;
    idle(5);

    // reset state
    cur_req = "R13";
    rd(5'd4, v);  chk("R13 enable", v, 0);
    rd(5'd8, v);  chk("R13 clkctl", v, 0);
    rd(5'd12, v); chk("R13 ctrl", v, 5);
    rd(5'd16, v); chk("R13 period", v, 0);
    rd(5'd20, v); chk("R13 duty", v, 0);
    chk("R13 output", int'(pwm_out), 0);

    // identification register
    cur_req = "R2";
    rd(5'd0, v); chk("R2 id", v, 'h34);
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, v); chk("R2 id after write", v, 'h34);

    // masked writes
    cur_req = "R1";
    wr(5'd12, {16'h0000, 16'hFFFF});
    rd(5'd12, v); chk("R1 zero mask", v, 5);
    wr(5'd12, {16'h0008, 16'h0008});
    rd(5'd12, v); chk("R1 set bit3", v, 'hD);
    wr(5'd12, {16'h0008, 16'h0000});
    rd(5'd12, v); chk("R1 clear bit3", v, 5);
    wr(5'd8, {16'h0003, 16'h1FF7});
    rd(5'd8, v); chk("R1 clkctl partial", v, 3);
    wr(5'd8, {16'hFFFF, 16'h0000});

    // shadow load while stopped, then run
    cur_req = "R6";
    wr(5'd16, 32'd10);
    wr(5'd20, 32'd3);
    rd(5'd16, v); chk("R6 period shadow", v, 10);
    rd(5'd20, v); chk("R6 duty shadow", v, 3);
    chk("R6 output idle", int'(pwm_out), 0);
    cur_req = "R7";
    wr(5'd4, {16'h0004, 16'h0004});
    idle(1);
    rd(5'd4, v); chk("R7 load self-clear", v, 0);
    cur_req = "R4";
    wr(5'd4, {16'h0003, 16'h0003});
    idle(3);
    highs(20, h); chk("R4 duty 3 of 10", h, 6);

    // shadow writes without load leave waveform
    cur_req = "R6";
    wr(5'd16, 32'd8);
    wr(5'd20, 32'd8);
    highs(20, h); chk("R6 unloaded shadow", h, 6);

    // duty >= period
    cur_req = "R5";
    wr(5'd4, {16'h0004, 16'h0004});
    idle(12);
    highs(10, h); chk("R5 full duty", h, 10);

    // lock holds a pending load
    cur_req = "R8";
    wr(5'd4, {16'h0008, 16'h0008});
    wr(5'd20, 32'd0);
    wr(5'd12, {16'h000C, 16'h0000});
    wr(5'd4, {16'h0004, 16'h0004});
    highs(20, h); chk("R8 locked waveform", h, 20);
    rd(5'd4, v); chk("R8 load pending", (v >> 2) & 1, 1);
    wr(5'd4, {16'h0008, 16'h0000});
    idle(12);
    highs(8, h); chk("R8 after unlock zero duty", h, 0);
    rd(5'd4, v); chk("R7 load cleared", (v >> 2) & 1, 0);

    // inverted polarity
    cur_req = "R4";
    wr(5'd16, 32'd6);
    wr(5'd20, 32'd2);
    wr(5'd12, {16'h000C, 16'h0008});
    wr(5'd4, {16'h0004, 16'h0004});
    idle(15);
    highs(12, h); chk("R4 active-low polarity", h, 8);

    // output enable cleared
    cur_req = "R10";
    wr(5'd4, {16'h0002, 16'h0000});
    idle(1);
    chk("R10 idle next clock", int'(pwm_out), 1);
    idle(2);

    // oneshot
    cur_req = "R9";
    wr(5'd12, {16'h000F, 16'h0004});
    wr(5'd16, 32'd5);
    wr(5'd20, 32'd2);
    wr(5'd4, {16'h0004, 16'h0004});
    idle(2);
    wr(5'd4, {16'h0002, 16'h0002});
    highs(12, h); chk("R9 single period", h, 2);
    rd(5'd4, v); chk("R9 out enable cleared", (v >> 1) & 1, 0);

    // prescaler
    cur_req = "R11";
    wr(5'd12, {16'h0003, 16'h0001});
    wr(5'd8, {16'hFFFF, 16'h0021});
    rd(5'd8, v); chk("R11 clkctl", v, 'h21);
    wr(5'd16, 32'd4);
    wr(5'd20, 32'd1);
    wr(5'd4, {16'h0004, 16'h0004});
    idle(2);
    wr(5'd4, {16'h0002, 16'h0002});
    idle(30);
    highs(48, h); chk("R11 divided waveform", h, 12);

    // capture/reserved modes park
    cur_req = "R12";
    wr(5'd12, {16'h0003, 16'h0002});
    idle(2);
    highs(10, h); chk("R12 mode 2 idle", h, 0);

    // clock enable off
    cur_req = "R3";
    wr(5'd12, {16'h0003, 16'h0001});
    wr(5'd4, {16'h0001, 16'h0000});
    idle(2);
    highs(10, h); chk("R3 clock enable off", h, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule